// File: doc/BRIEF.md
# Streaming Value Range Profiler

The profiler watches a stream of signed two's-complement samples that belong to one variable. It keeps four extreme values. Two are the values farthest from zero on each side of zero. The other two are the values closest to zero on each side. It also keeps a distribution histogram whose intervals grow by powers of two in magnitude, with a separate counter for each sign.

The widest values give the integer width that a fixed-point format needs. The widest and narrowest magnitudes together bound the exponent range that a floating-point format needs. Zero samples go to a counter of their own.

A synchronous clear returns every record to its empty state. Software, or a neighbouring block, reads the records one word at a time through an address port. Each read has one cycle of latency.

Top module: `range_profiler`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, both seen flags are 0. The largest positive and most negative records hold 0, the smallest positive record holds the largest representable positive value, and the negative record closest to zero holds the most negative representable value. All counters hold 0. When `clr` and `in_valid` are both high, the clear wins and the sample is dropped.
- R2: Every accepted sample updates its record in the same cycle: a positive sample raises the largest positive record (address 0) when it exceeds it, and a negative sample lowers the most negative record (address 1) when it is below it. The first sample of each sign after a clear loads the record directly.
- R3: The smallest positive record (address 2) follows the minimum of the positive samples. The record closest to zero on the negative side (address 3) follows the maximum of the negative samples.
- R4: A zero sample increments the zero counter (address 4). It changes no extreme, no seen flag and no bucket counter.
- R5: A nonzero sample with magnitude m goes to bucket k, where k is the position of the leading one of m (so 2^k <= m < 2^(k+1)). The magnitude of the most negative value is 2^(DATA_W-1). Positive samples increment the counter at address 8+2k, and negative samples increment the counter at address 9+2k.
- R6: Every counter stops at its all-ones value and does not wrap.
- R7: When `rd_en` is high at a clock edge, `rd_valid` is high after that edge and `rd_data` holds the word at `rd_addr`, taken from the records as they stood before that edge's update. Otherwise `rd_valid` is low. Unmapped addresses (6, 7, and anything above the last bucket) return 0.
- R8: Address 5 returns the seen flags: bit 0 is set once a positive sample has arrived, and bit 1 is set once a negative sample has arrived.
- R9: While `in_valid` is low, no record changes, whatever `in_data` holds.
- R10: Extremes are returned sign-extended to the read width, and counters and flags are returned zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all records |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | DATA_W | Signed sample |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | RD_W | Read word |

## Verification
The checker watches several properties on every cycle:
- the clear empties the seen flags;
- the far-from-zero records only move outward between clears;
- once a side has been seen, its near-zero record lies between zero and its far record;
- zero samples leave the near-zero records untouched;
- a saturated zero counter stays saturated;
- idle cycles change nothing;
- the read valid follows the request by exactly one cycle.

Only the bench scenarios can show the values themselves: the exact bucket chosen for each magnitude, including the most negative input; saturation of the bucket counters; clear winning over a sample in the same cycle; and the read-before-update ordering. The bench checks these against a behavioural model on every clock.

// File: rtl/rp_pkg.sv
package rp_pkg;

    // Classification of one accepted sample
    typedef enum logic [1:0] {
        KIND_ZERO = 2'd0,
        KIND_POS  = 2'd1,
        KIND_NEG  = 2'd2
    } kind_e;

    // Read map: fixed words first, bucket pairs from BKT_BASE
    localparam int ADR_MAX_POS = 0;
    localparam int ADR_MIN_NEG = 1;
    localparam int ADR_MIN_POS = 2;
    localparam int ADR_MAX_NEG = 3;
    localparam int ADR_ZERO    = 4;
    localparam int ADR_FLAGS   = 5;
    localparam int BKT_BASE    = 8;

endpackage

// File: rtl/rp_classify.sv
module rp_classify
    import rp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              [DATA_W-1:0] data,
    output kind_e                          kind,
    output logic              [IDX_W-1:0]  idx
);

    logic [DATA_W-1:0] mag;

    always_comb begin
        if (data == '0) begin
            kind = KIND_ZERO;
        end else if (data[DATA_W-1]) begin
            kind = KIND_NEG;
        end else begin
            kind = KIND_POS;
        end
        // Unsigned magnitude; the most negative input maps to 2^(DATA_W-1)
        mag = data[DATA_W-1] ? (~data + 1'b1) : data;
        idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (mag[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rp_extremes.sv
module rp_extremes
    import rp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     upd,
    input  kind_e                    kind,
    input  logic signed [DATA_W-1:0] data,
    output logic signed [DATA_W-1:0] max_pos,
    output logic signed [DATA_W-1:0] min_pos,
    output logic signed [DATA_W-1:0] max_neg,
    output logic signed [DATA_W-1:0] min_neg,
    output logic                     pos_seen,
    output logic                     neg_seen
);

    localparam logic [DATA_W-1:0] POS_TOP = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_BOT = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] max_pos;
        logic [DATA_W-1:0] min_pos;
        logic [DATA_W-1:0] max_neg;
        logic [DATA_W-1:0] min_neg;
        logic              pos_seen;
        logic              neg_seen;
    } ext_t;

    localparam ext_t EMPTY = '{max_pos: '0, min_pos: POS_TOP, max_neg: NEG_BOT,
                               min_neg: '0, pos_seen: 1'b0, neg_seen: 1'b0};

    ext_t ext_d, ext_q;

    always_comb begin
        ext_d = ext_q;
        if (clr) begin
            ext_d = EMPTY;
        end else if (upd) begin
            if (kind == KIND_POS) begin
                ext_d.pos_seen = 1'b1;
                if (!ext_q.pos_seen || (data > $signed(ext_q.max_pos))) begin
                    ext_d.max_pos = data;
                end
                if (!ext_q.pos_seen || (data < $signed(ext_q.min_pos))) begin
                    ext_d.min_pos = data;
                end
            end else if (kind == KIND_NEG) begin
                ext_d.neg_seen = 1'b1;
                if (!ext_q.neg_seen || (data < $signed(ext_q.min_neg))) begin
                    ext_d.min_neg = data;
                end
                if (!ext_q.neg_seen || (data > $signed(ext_q.max_neg))) begin
                    ext_d.max_neg = data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= EMPTY;
        end else begin
            ext_q <= ext_d;
        end
    end

    assign max_pos  = ext_q.max_pos;
    assign min_pos  = ext_q.min_pos;
    assign max_neg  = ext_q.max_neg;
    assign min_neg  = ext_q.min_neg;
    assign pos_seen = ext_q.pos_seen;
    assign neg_seen = ext_q.neg_seen;

endmodule

// File: rtl/rp_satcnt.sv
module rp_satcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !(&cnt_q)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rp_hist.sv
module rp_hist
    import rp_pkg::*;
#(
    parameter int N_BKT = 16,
    parameter int CNT_W = 16,
    parameter int IDX_W = $clog2(N_BKT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         upd,
    input  kind_e                        kind,
    input  logic [IDX_W-1:0]             idx,
    output logic [N_BKT-1:0][CNT_W-1:0]  pos_cnt,
    output logic [N_BKT-1:0][CNT_W-1:0]  neg_cnt,
    output logic [CNT_W-1:0]             zero_cnt
);

    rp_satcnt #(.CNT_W(CNT_W)) u_zero (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .inc(upd && (kind == KIND_ZERO)),
        .cnt(zero_cnt)
    );

    for (genvar k = 0; k < N_BKT; k++) begin : g_bkt
        logic hit;
        assign hit = upd && (idx == IDX_W'(k));

        rp_satcnt #(.CNT_W(CNT_W)) u_pos (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .inc(hit && (kind == KIND_POS)),
            .cnt(pos_cnt[k])
        );
        rp_satcnt #(.CNT_W(CNT_W)) u_neg (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .inc(hit && (kind == KIND_NEG)),
            .cnt(neg_cnt[k])
        );
    end

endmodule

// File: rtl/range_profiler.sv
module range_profiler
    import rp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    localparam int N_BKT  = DATA_W,
    localparam int N_ADDR = BKT_BASE + 2 * N_BKT,
    localparam int ADDR_W = $clog2(N_ADDR),
    localparam int RD_W   = (DATA_W > CNT_W) ? DATA_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data
);

    localparam int IDX_W = $clog2(N_BKT);

    kind_e                          kind;
    logic [IDX_W-1:0]               idx;
    logic signed [DATA_W-1:0]       max_pos, min_pos, max_neg, min_neg;
    logic                           pos_seen, neg_seen;
    logic [N_BKT-1:0][CNT_W-1:0]    pos_cnt, neg_cnt;
    logic [CNT_W-1:0]               zero_cnt;

    rp_classify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cls (
        .data(in_data), .kind(kind), .idx(idx)
    );

    rp_extremes #(.DATA_W(DATA_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(in_valid),
        .kind(kind), .data($signed(in_data)),
        .max_pos(max_pos), .min_pos(min_pos),
        .max_neg(max_neg), .min_neg(min_neg),
        .pos_seen(pos_seen), .neg_seen(neg_seen)
    );

    rp_hist #(.N_BKT(N_BKT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(in_valid),
        .kind(kind), .idx(idx),
        .pos_cnt(pos_cnt), .neg_cnt(neg_cnt), .zero_cnt(zero_cnt)
    );

    typedef struct packed {
        logic            valid;
        logic [RD_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        case (rd_addr)
            ADDR_W'(ADR_MAX_POS): rd_d.data = RD_W'(max_pos);
            ADDR_W'(ADR_MIN_NEG): rd_d.data = RD_W'(min_neg);
            ADDR_W'(ADR_MIN_POS): rd_d.data = RD_W'(min_pos);
            ADDR_W'(ADR_MAX_NEG): rd_d.data = RD_W'(max_neg);
            ADDR_W'(ADR_ZERO):    rd_d.data = RD_W'(zero_cnt);
            ADDR_W'(ADR_FLAGS):   rd_d.data = RD_W'({neg_seen, pos_seen});
            default: begin
                for (int k = 0; k < N_BKT; k++) begin
                    if (rd_addr == ADDR_W'(BKT_BASE + 2 * k)) begin
                        rd_d.data = RD_W'(pos_cnt[k]);
                    end
                    if (rd_addr == ADDR_W'(BKT_BASE + 2 * k + 1)) begin
                        rd_d.data = RD_W'(neg_cnt[k]);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

endmodule

// File: rtl/range_profiler_chk.sv
module range_profiler_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr,
    input logic                     in_valid,
    input logic [DATA_W-1:0]        in_data,
    input logic                     rd_en,
    input logic                     rd_valid,
    input logic                     pos_seen,
    input logic                     neg_seen,
    input logic signed [DATA_W-1:0] max_pos,
    input logic signed [DATA_W-1:0] min_pos,
    input logic signed [DATA_W-1:0] max_neg,
    input logic signed [DATA_W-1:0] min_neg,
    input logic [CNT_W-1:0]         zero_cnt
);

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!pos_seen && !neg_seen));

    assert_far_outward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pos_seen && neg_seen) |=>
            ((max_pos >= $past(max_pos)) && (min_neg <= $past(min_neg))));

    assert_pos_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pos_seen |-> ((min_pos > 0) && (min_pos <= max_pos)));

    assert_neg_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        neg_seen |-> ((max_neg < 0) && (min_neg <= max_neg)));

    assert_zero_no_extreme_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && (in_data == '0)) |=>
            ($stable(min_pos) && $stable(max_neg) && $stable(pos_seen) && $stable(neg_seen)));

    assert_zero_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (&zero_cnt)) |=> (&zero_cnt));

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=>
            ($stable(max_pos) && $stable(min_pos) && $stable(max_neg) &&
             $stable(min_neg) && $stable(zero_cnt)));

endmodule

bind range_profiler range_profiler_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_range_profiler.sv
`timescale 1ns/1ps
module test_range_profiler;

    localparam int DW = 16;
    localparam int CW = 8;
    localparam int AW = 6;
    localparam int NA = 8 + 2 * DW;
    localparam int CMAX = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    range_profiler #(.DATA_W(DW), .CNT_W(CW)) i_range_profiler (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int maxp, minp, maxn, minn, zc;
    bit ps, ns;
    int pc[DW];
    int nc[DW];

    bit            pend;
    logic [DW-1:0] pend_exp;
    string         pend_tag;
    string         force_tag = "";

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        ps = 0; ns = 0;
        maxp = 0; minp = 32767; maxn = -32768; minn = 0; zc = 0;
        for (int k = 0; k < DW; k++) begin
            pc[k] = 0;
            nc[k] = 0;
        end
    endfunction

    function automatic int bump(input int c);
        return (c < CMAX) ? c + 1 : c;
    endfunction

    function automatic void model_sample(input int v);
        int m;
        int b;
        if (v == 0) begin
            zc = bump(zc);
        end else begin
            m = (v < 0) ? -v : v;
            b = $clog2(m + 1) - 1;
            if (v > 0) begin
                if (!ps) begin maxp = v; minp = v; end
                else begin
                    if (v > maxp) maxp = v;
                    if (v < minp) minp = v;
                end
                ps = 1;
                pc[b] = bump(pc[b]);
            end else begin
                if (!ns) begin minn = v; maxn = v; end
                else begin
                    if (v < minn) minn = v;
                    if (v > maxn) maxn = v;
                end
                ns = 1;
                nc[b] = bump(nc[b]);
            end
        end
    endfunction

    function automatic logic [DW-1:0] exp_read(input int a);
        int w;
        case (a)
            0: w = maxp;
            1: w = minn;
            2: w = minp;
            3: w = maxn;
            4: w = zc;
            5: w = (int'(ns) << 1) | int'(ps);
            default: begin
                if (a >= 8 && a < NA) w = ((a % 2) == 1) ? nc[(a - 8) / 2] : pc[(a - 8) / 2];
                else w = 0;
            end
        endcase
        return w[DW-1:0];
    endfunction

    function automatic string tag_for(input int a);
        if (a <= 1) return "R2";
        if (a <= 3) return "R3";
        if (a == 4) return "R4";
        if (a == 5) return "R8";
        if (a < NA && a >= 8) return "R5";
        return "R7";
    endfunction

    // One clock: check previous read, drive new inputs, advance the model
    task automatic step(input bit v, input int d, input bit c, input bit r, input int a);
        @(negedge clk);
        chk(rd_valid == pend, "R7 rd_valid", {15'd0, rd_valid}, {15'd0, pend});
        if (pend) chk(rd_data === pend_exp, pend_tag, rd_data, pend_exp);
        in_valid = v;
        in_data  = d[DW-1:0];
        clr      = c;
        rd_en    = r;
        rd_addr  = a[AW-1:0];
        pend     = r;
        pend_exp = exp_read(a);
        pend_tag = (force_tag != "") ? force_tag : tag_for(a);
        if (c) model_clear();
        else if (v) model_sample(d);
    endtask

    task automatic read_all(input string tag);
        force_tag = tag;
        for (int a = 0; a < NA; a++) step(0, 0, 0, 1, a);
        force_tag = "";
    endtask

    initial begin
        int lfsr;
        model_clear();
        pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 reset rd_valid", {15'd0, rd_valid}, '0);
        rst_n = 1'b1;

        // R1: reset state, sentinels read back
        read_all("R1");

        // R2 R3 R5 R10: mixed signs, extremes at both ends, most negative input
        step(1, 100, 0, 1, 0);
        step(1, -3, 0, 1, 1);
        step(1, 1, 0, 1, 2);
        step(1, -32768, 0, 1, 3);
        step(1, 32767, 0, 1, 38);
        step(1, 7, 0, 1, 39);
        step(1, -1, 0, 1, 9);
        step(1, 0, 0, 1, 4);
        step(1, 0, 0, 1, 5);
        step(1, 64, 0, 1, 20);
        step(1, -200, 0, 1, 23);
        read_all("");

        // R9: garbage data with in_valid low
        for (int i = 0; i < 5; i++) step(0, 12345 - i * 999, 0, 0, 0);
        read_all("R9");

        // R1: clear wins over a simultaneous sample
        step(1, 50, 1, 0, 0);
        read_all("R1");

        // R6: saturation of bucket and zero counters
        for (int i = 0; i < 300; i++) step(1, 5, 0, 0, 0);
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0);
        for (int i = 0; i < 270; i++) step(1, -6, 0, 0, 0);
        read_all("R6");

        // R2 R3 R5: pseudo-random stream with rotating reads
        step(1, 0, 1, 0, 0);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = ((lfsr >> 1) ^ (((lfsr & 1) != 0) ? 16'hB400 : 16'h0)) & 16'hFFFF;
            step(1, (lfsr >= 32768) ? lfsr - 65536 : lfsr, 0, 1, i % NA);
        end
        read_all("");
        step(0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule